// File: doc/BRIEF.md
# CPU Bootstrap Bus-Injection Sequencer

This block loads a program image into the RAM of a small 8-bit processor system that has no boot ROM. It owns the processor's clock and reset lines. It never looks at or drives the address bus. Instead, it counts processor cycles against the clock it generates, and in each read cycle it places the byte that a ROM would have returned. The processor first fetches a reset vector of $0300. It then runs a three-instruction loop: load immediate, store absolute, jump back to $0300. The immediate operand of each pass is the next image byte, and the store address begins at a base and steps up by one per pass. A boot-mode line tells the external memory decoder to make RAM write-only while the load runs.

When the write to $FFFF is done, the block drops boot mode and asserts the processor reset. It switches the processor clock to a free-running clock at half the system clock and holds reset for a set number of processor cycles. It then releases reset, so the processor restarts from the reset vector that now sits in RAM, and it raises `done`. Image bytes come from an external source through a request/valid handshake. While no byte is offered, the injected clock waits in its low phase.

The sequencer states are as follows:
- ST_RST_HOLD: reset held while clocking.
- ST_RST_RUN: reset released, six undriven cycles.
- ST_VEC_LO and ST_VEC_HI: the reset-vector bytes.
- ST_LDA_OP and ST_LDA_IMM: the load opcode and the image byte.
- ST_STA_OP, ST_STA_LO and ST_STA_HI: the store opcode and the two address bytes.
- ST_STA_WR: the write cycle, with the bus released.
- ST_JMP_OP, ST_JMP_LO and ST_JMP_HI: the jump back to the loop.
- ST_FINAL_RST: free clock, reset asserted.
- ST_DONE: idle until the block's own reset.

Each injected state lasts one processor cycle and moves to the next state in the order above. ST_RST_HOLD and ST_RST_RUN repeat until their counts run out. ST_STA_WR goes to ST_FINAL_RST after the write to $FFFF and to ST_JMP_OP otherwise. ST_JMP_HI returns to ST_LDA_OP. ST_FINAL_RST goes to ST_DONE after its count.

Top module: `boot_inject_loader`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it: `cpu_rst_n`=0, `boot_mode`=1, `cpu_clk`=0, `bus_oe`=0, `img_req`=0 and `done`=0.
- R2: Each injected processor cycle is a low phase of at least HALF_TICKS system clocks, followed by a high phase of exactly HALF_TICKS system clocks. The first RESET_HOLD_CYCLES (default 4) cycles run with `cpu_rst_n`=0 and the bus undriven. After them `cpu_rst_n` goes to 1.
- R3: After reset is released, RESET_IDLE_CYCLES (default 6) cycles pass with the bus undriven. The next two cycles drive $00 and then $03.
- R4: `bus_oe` is 1 only while `cpu_clk` is 1 and `boot_mode` is 1. It is 0 on the last system clock of every high phase, so the bus is free before the clock falls. `bus_data` is valid whenever `bus_oe` is 1.
- R5: Each loop pass drives the bytes $A9, then the image byte, $8D, the address low byte, and the address high byte. One cycle with the bus undriven follows. Unless loading has finished, the pass then drives $4C, $00, $03.
- R6: The store address starts at BASE_ADDR and rises by one per pass. The pass that stores to $FFFF is the last, and it ends with its undriven write cycle, with no jump bytes.
- R7: `boot_mode` stays 1 for the whole load and falls together with the last write cycle's clock fall. From then on `cpu_rst_n` is 0 for 2*FINAL_RESET_CYCLES system clocks. `cpu_clk` toggles on every system clock, and `bus_oe` stays 0.
- R8: `img_req` is 1 during the low phase of the image-byte cycle until a byte is taken on a clock where `img_valid` is 1. While it waits, `cpu_clk` stays 0. Exactly one byte is taken per pass.
- R9: `done` goes to 1 on the same clock that `cpu_rst_n` returns to 1 after the load. It stays 1, with `img_req` at 0, until `rst_n` is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset of the sequencer |
| img_valid | input | 1 | Image source offers a byte |
| img_data | input | DATA_W | Offered image byte |
| img_req | output | 1 | Sequencer wants the next image byte |
| cpu_clk | output | 1 | Processor clock |
| cpu_rst_n | output | 1 | Processor reset, active low |
| boot_mode | output | 1 | Memory decoder select: 1 = load map (RAM write-only) |
| bus_oe | output | 1 | Data bus driver enable |
| bus_data | output | DATA_W | Byte driven on the data bus |
| done | output | 1 | Load finished and processor released |

## Verification
The assertions check the following on every cycle:
- The bus is only driven during a high phase in boot mode, and it is still high one clock after any driven clock.
- The clock stays low while a byte request is unanswered.
- The clock toggles freely once boot mode has ended.
- Boot mode falls with reset asserted.
- `done` never drops.

Only the bench's scenarios can show the following:
- The exact byte order of the reset sequence and of the loader loop.
- The address bytes and the stop after $FFFF.
- The length of the final reset.
- One byte is taken per pass under random source delays.

// File: rtl/boot_inject_pkg.sv
package boot_inject_pkg;

    typedef enum logic [3:0] {
        ST_RST_HOLD,
        ST_RST_RUN,
        ST_VEC_LO,
        ST_VEC_HI,
        ST_LDA_OP,
        ST_LDA_IMM,
        ST_STA_OP,
        ST_STA_LO,
        ST_STA_HI,
        ST_STA_WR,
        ST_JMP_OP,
        ST_JMP_LO,
        ST_JMP_HI,
        ST_FINAL_RST,
        ST_DONE
    } boot_state_e;

    localparam logic [7:0] OPC_LOAD_IMM  = 8'hA9;
    localparam logic [7:0] OPC_STORE_ABS = 8'h8D;
    localparam logic [7:0] OPC_JUMP_ABS  = 8'h4C;
    localparam logic [7:0] LOOP_ADDR_LO  = 8'h00;
    localparam logic [7:0] LOOP_ADDR_HI  = 8'h03;

endpackage

// File: rtl/boot_phase_timer.sv
module boot_phase_timer #(
    parameter int HALF_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic high_phase,
    output logic last_tick,
    output logic cycle_end
);
    localparam int TICK_W = (HALF_TICKS > 2) ? $clog2(HALF_TICKS) : 1;
    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(HALF_TICKS - 1);

    logic [TICK_W-1:0] tick_q;
    logic              high_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= '0;
            high_q <= 1'b0;
        end else if (run) begin
            if (tick_q == TICK_LAST) begin
                tick_q <= '0;
                high_q <= ~high_q;
            end else begin
                tick_q <= tick_q + 1'b1;
            end
        end
    end

    assign high_phase = high_q;
    assign last_tick  = (tick_q == TICK_LAST);
    assign cycle_end  = run && high_q && (tick_q == TICK_LAST);

endmodule

// File: rtl/boot_byte_select.sv
module boot_byte_select
    import boot_inject_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  boot_state_e        state,
    input  logic [DATA_W-1:0]  image_byte,
    input  logic [ADDR_W-1:0]  store_addr,
    output logic               drive,
    output logic [DATA_W-1:0]  value
);
    always_comb begin
        drive = 1'b1;
        value = '0;
        unique case (state)
            ST_VEC_LO:  value = DATA_W'(LOOP_ADDR_LO);
            ST_VEC_HI:  value = DATA_W'(LOOP_ADDR_HI);
            ST_LDA_OP:  value = DATA_W'(OPC_LOAD_IMM);
            ST_LDA_IMM: value = image_byte;
            ST_STA_OP:  value = DATA_W'(OPC_STORE_ABS);
            ST_STA_LO:  value = store_addr[DATA_W-1:0];
            ST_STA_HI:  value = store_addr[ADDR_W-1:ADDR_W-DATA_W];
            ST_JMP_OP:  value = DATA_W'(OPC_JUMP_ABS);
            ST_JMP_LO:  value = DATA_W'(LOOP_ADDR_LO);
            ST_JMP_HI:  value = DATA_W'(LOOP_ADDR_HI);
            ST_RST_HOLD, ST_RST_RUN, ST_STA_WR,
            ST_FINAL_RST, ST_DONE: drive = 1'b0;
            default:    drive = 1'b0;
        endcase
    end

endmodule

// File: rtl/boot_inject_loader.sv
module boot_inject_loader
    import boot_inject_pkg::*;
#(
    parameter int              ADDR_W              = 16,
    parameter int              DATA_W              = 8,
    parameter int              HALF_TICKS          = 4,
    parameter int              RESET_HOLD_CYCLES   = 4,
    parameter int              RESET_IDLE_CYCLES   = 6,
    parameter int              FINAL_RESET_CYCLES  = 4,
    parameter logic [15:0]     BASE_ADDR           = 16'hD000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              img_valid,
    input  logic [DATA_W-1:0] img_data,
    output logic              img_req,
    output logic              cpu_clk,
    output logic              cpu_rst_n,
    output logic              boot_mode,
    output logic              bus_oe,
    output logic [DATA_W-1:0] bus_data,
    output logic              done
);
    localparam int CNT_W = $clog2(RESET_HOLD_CYCLES + RESET_IDLE_CYCLES
                                  + 2 * FINAL_RESET_CYCLES + 1);
    localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(RESET_HOLD_CYCLES - 1);
    localparam logic [CNT_W-1:0] IDLE_LAST  = CNT_W'(RESET_IDLE_CYCLES - 1);
    localparam logic [CNT_W-1:0] FINAL_LAST = CNT_W'(2 * FINAL_RESET_CYCLES - 1);

    boot_state_e        state_q, state_d;
    logic [CNT_W-1:0]   cyc_cnt_q;
    logic [ADDR_W-1:0]  store_addr_q;
    logic [DATA_W-1:0]  img_byte_q;
    logic               have_byte_q;
    logic               free_clk_q;

    logic               free_mode;
    logic               stall;
    logic               timer_run;
    logic               high_phase;
    logic               last_tick;
    logic               cycle_end;
    logic               sel_drive;
    logic [DATA_W-1:0]  sel_value;
    logic               take_byte;

    assign free_mode = (state_q == ST_FINAL_RST) || (state_q == ST_DONE);
    assign stall     = (state_q == ST_LDA_IMM) && !high_phase && last_tick && !have_byte_q;
    assign timer_run = !free_mode && !stall;
    assign take_byte = img_req && img_valid;

    boot_phase_timer #(.HALF_TICKS(HALF_TICKS)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (timer_run),
        .high_phase (high_phase),
        .last_tick  (last_tick),
        .cycle_end  (cycle_end)
    );

    boot_byte_select #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_select (
        .state      (state_q),
        .image_byte (img_byte_q),
        .store_addr (store_addr_q),
        .drive      (sel_drive),
        .value      (sel_value)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RST_HOLD;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RST_HOLD:  if (cycle_end && cyc_cnt_q == HOLD_LAST) state_d = ST_RST_RUN;
            ST_RST_RUN:   if (cycle_end && cyc_cnt_q == IDLE_LAST) state_d = ST_VEC_LO;
            ST_VEC_LO:    if (cycle_end) state_d = ST_VEC_HI;
            ST_VEC_HI:    if (cycle_end) state_d = ST_LDA_OP;
            ST_LDA_OP:    if (cycle_end) state_d = ST_LDA_IMM;
            ST_LDA_IMM:   if (cycle_end) state_d = ST_STA_OP;
            ST_STA_OP:    if (cycle_end) state_d = ST_STA_LO;
            ST_STA_LO:    if (cycle_end) state_d = ST_STA_HI;
            ST_STA_HI:    if (cycle_end) state_d = ST_STA_WR;
            ST_STA_WR:    if (cycle_end) state_d = (&store_addr_q) ? ST_FINAL_RST : ST_JMP_OP;
            ST_JMP_OP:    if (cycle_end) state_d = ST_JMP_LO;
            ST_JMP_LO:    if (cycle_end) state_d = ST_JMP_HI;
            ST_JMP_HI:    if (cycle_end) state_d = ST_LDA_OP;
            ST_FINAL_RST: if (cyc_cnt_q == FINAL_LAST) state_d = ST_DONE;
            ST_DONE:      state_d = ST_DONE;
            default:      state_d = ST_RST_HOLD;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_cnt_q    <= '0;
            store_addr_q <= ADDR_W'(BASE_ADDR);
            img_byte_q   <= '0;
            have_byte_q  <= 1'b0;
            free_clk_q   <= 1'b0;
        end else begin
            if (take_byte) begin
                img_byte_q  <= img_data;
                have_byte_q <= 1'b1;
            end
            if (cycle_end && state_q == ST_LDA_IMM) have_byte_q <= 1'b0;
            if (cycle_end && state_q == ST_STA_WR) store_addr_q <= store_addr_q + 1'b1;
            if (state_q == ST_FINAL_RST) begin
                cyc_cnt_q <= cyc_cnt_q + 1'b1;
            end else if (cycle_end && state_q == ST_RST_HOLD) begin
                cyc_cnt_q <= (cyc_cnt_q == HOLD_LAST) ? '0 : cyc_cnt_q + 1'b1;
            end else if (cycle_end && state_q == ST_RST_RUN) begin
                cyc_cnt_q <= (cyc_cnt_q == IDLE_LAST) ? '0 : cyc_cnt_q + 1'b1;
            end
            if (free_mode) free_clk_q <= ~free_clk_q;
        end
    end

    // Outputs
    always_comb begin
        boot_mode = !free_mode;
        cpu_clk   = free_mode ? free_clk_q : high_phase;
        cpu_rst_n = !((state_q == ST_RST_HOLD) || (state_q == ST_FINAL_RST));
        bus_oe    = sel_drive && high_phase && !last_tick && !free_mode;
        bus_data  = bus_oe ? sel_value : '0;
        img_req   = (state_q == ST_LDA_IMM) && !have_byte_q;
        done      = (state_q == ST_DONE);
    end

    // R4: bus driven only in a boot-mode high phase
    assert_oe_high_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (cpu_clk && boot_mode));

    // R4: a driven clock is never the last of its high phase
    assert_release_before_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |=> cpu_clk);

    // R8: an unanswered request keeps the processor clock low
    assert_stall_clock_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (img_req && !img_valid) |=> !cpu_clk);

    // R7: free-running clock toggles every system clock after boot mode ends
    assert_free_clock_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!boot_mode && $past(!boot_mode)) |-> (cpu_clk != $past(cpu_clk)));

    // R7: leaving boot mode asserts the processor reset
    assert_exit_with_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(boot_mode) |-> !cpu_rst_n);

    // R9: done is sticky
    assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && !img_req));

endmodule

// File: tb/sim_boot_inject_loader.sv
`timescale 1ns/1ps
module sim_boot_inject_loader;
    localparam int          HALF   = 3;
    localparam logic [15:0] BASE   = 16'hFFF0;
    localparam int          NBYTES = 16;
    localparam int          FINALC = 4;
    localparam int          EXP_N  = 4 + 6 + 2 + NBYTES * 6 + (NBYTES - 1) * 3;
    localparam int          WD_LIMIT = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       img_valid = 1'b0;
    logic [7:0] img_data = 8'h00;
    logic       img_req, cpu_clk, cpu_rst_n, boot_mode, bus_oe, done;
    logic [7:0] bus_data;

    always #2.5 clk = ~clk;

    boot_inject_loader #(
        .HALF_TICKS(HALF), .FINAL_RESET_CYCLES(FINALC), .BASE_ADDR(BASE)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .img_valid(img_valid), .img_data(img_data),
        .img_req(img_req), .cpu_clk(cpu_clk), .cpu_rst_n(cpu_rst_n),
        .boot_mode(boot_mode), .bus_oe(bus_oe), .bus_data(bus_data), .done(done)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected stream: drive flag, value, reset level
    bit        exp_drv [EXP_N];
    logic [7:0] exp_val [EXP_N];
    bit        exp_rst [EXP_N];
    logic [7:0] image  [NBYTES];

    function automatic logic [7:0] addr_byte(input int j, input bit hi);
        logic [15:0] a;
        a = BASE + 16'(j);
        return hi ? a[15:8] : a[7:0];
    endfunction

    task automatic build_expected();
        int p = 0;
        for (int i = 0; i < 4; i++) begin exp_drv[p]=0; exp_val[p]=0; exp_rst[p]=0; p++; end
        for (int i = 0; i < 6; i++) begin exp_drv[p]=0; exp_val[p]=0; exp_rst[p]=1; p++; end
        exp_drv[p]=1; exp_val[p]=8'h00; exp_rst[p]=1; p++;
        exp_drv[p]=1; exp_val[p]=8'h03; exp_rst[p]=1; p++;
        for (int j = 0; j < NBYTES; j++) begin
            exp_drv[p]=1; exp_val[p]=8'hA9;           exp_rst[p]=1; p++;
            exp_drv[p]=1; exp_val[p]=image[j];        exp_rst[p]=1; p++;
            exp_drv[p]=1; exp_val[p]=8'h8D;           exp_rst[p]=1; p++;
            exp_drv[p]=1; exp_val[p]=addr_byte(j, 0); exp_rst[p]=1; p++;
            exp_drv[p]=1; exp_val[p]=addr_byte(j, 1); exp_rst[p]=1; p++;
            exp_drv[p]=0; exp_val[p]=8'h00;           exp_rst[p]=1; p++;
            if (j != NBYTES - 1) begin
                exp_drv[p]=1; exp_val[p]=8'h4C; exp_rst[p]=1; p++;
                exp_drv[p]=1; exp_val[p]=8'h00; exp_rst[p]=1; p++;
                exp_drv[p]=1; exp_val[p]=8'h03; exp_rst[p]=1; p++;
            end
        end
    endtask

    // Image source with random delays
    int fetched  = 0;
    int wait_cnt = 0;
    int long_at  = -1;
    always @(negedge clk) begin
        if (img_valid) begin
            img_valid <= 1'b0;
            fetched++;
            wait_cnt = (fetched == long_at) ? 10 : int'($urandom_range(0, 3));
        end else if (img_req && rst_n) begin
            if (wait_cnt == 0) begin
                img_valid <= 1'b1;
                img_data  <= image[fetched % NBYTES];
            end else begin
                wait_cnt--;
            end
        end
    end

    // Cycle monitor
    bit        mon_en = 0;
    int        widx = 0, hi_len = 0;
    bit        cap_drv = 0, cap_rst = 0, prev_clk = 0, prev_oe = 0, prev_boot = 1;
    logic [7:0] cap_val = 0;
    int        oe_low_err = 0, stall_err = 0;
    always @(negedge clk) begin
        if (mon_en) begin
            if (cpu_clk && boot_mode) begin
                hi_len++;
                cap_rst = cpu_rst_n;
                if (bus_oe) begin cap_drv = 1; cap_val = bus_data; end
            end
            if (bus_oe && (!cpu_clk || !boot_mode)) oe_low_err++;
            if (img_req && cpu_clk) stall_err++;
            if (prev_clk && !cpu_clk && prev_boot) begin
                if (widx < EXP_N) begin
                    check((cap_drv == exp_drv[widx]) && (cap_rst == exp_rst[widx]) &&
                          (!exp_drv[widx] || cap_val == exp_val[widx]),
                          (widx < 4) ? "R2 hold cycle" : (widx < 12) ? "R3 idle/vector" :
                          "R5/R6 loop byte",
                          {widx[15:0], 3'b0, cap_drv, 3'b0, cap_rst, cap_val},
                          {widx[15:0], 3'b0, exp_drv[widx], 3'b0, exp_rst[widx], exp_val[widx]});
                end
                check(hi_len == HALF, "R2 high phase length", hi_len, HALF);
                check(!prev_oe, "R4 released before fall", prev_oe, 0);
                widx++;
                hi_len = 0; cap_drv = 0; cap_val = 0;
            end
            prev_clk = cpu_clk; prev_oe = bus_oe; prev_boot = boot_mode;
        end
    end

    // Watchdog
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > WD_LIMIT) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=<%0d", wd, WD_LIMIT);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    task automatic run_load(input int seed_tag);
        int rstlen;
        int prevc;
        bit mid_rst_ok;
        for (int j = 0; j < NBYTES; j++) image[j] = 8'($urandom);
        if (seed_tag == 1) begin image[0] = 8'h00; image[NBYTES-1] = 8'hFF; end
        build_expected();
        rst_n = 1'b0;
        fetched = 0; wait_cnt = 0;
        long_at = (seed_tag == 1) ? 5 : 9;
        repeat (3) @(negedge clk);
        check({cpu_rst_n, boot_mode, cpu_clk, bus_oe, img_req, done} == 6'b010000,
              "R1 reset state", {cpu_rst_n, boot_mode, cpu_clk, bus_oe, img_req, done}, 6'b010000);
        widx = 0; hi_len = 0; cap_drv = 0; prev_clk = 0; prev_oe = 0; prev_boot = 1;
        oe_low_err = 0; stall_err = 0;
        mon_en = 1;
        rst_n = 1'b1;
        @(negedge clk);
        check({cpu_rst_n, boot_mode, cpu_clk, bus_oe, img_req, done} == 6'b010000,
              "R1 first cycle after reset", {cpu_rst_n, boot_mode, cpu_clk, bus_oe, img_req, done},
              6'b010000);
        while (boot_mode) @(negedge clk);
        // first sample out of boot mode
        check(!cpu_rst_n, "R7 reset asserted on exit", cpu_rst_n, 0);
        rstlen = 0;
        mid_rst_ok = 1;
        prevc = cpu_clk;
        while (!cpu_rst_n && rstlen < 100) begin
            rstlen++;
            if (done || bus_oe || boot_mode) mid_rst_ok = 0;
            @(negedge clk);
            if (cpu_clk == prevc) mid_rst_ok = 0;
            prevc = cpu_clk;
        end
        check(rstlen == 2 * FINALC, "R7 final reset length", rstlen, 2 * FINALC);
        check(mid_rst_ok, "R7 free clock, no drive, no done during final reset", mid_rst_ok, 1);
        check(done, "R9 done with reset release", done, 1);
        mon_en = 0;
        check(widx == EXP_N, "R5/R6 cycle count of load", widx, EXP_N);
        check(fetched == NBYTES, "R8 bytes taken", fetched, NBYTES);
        check(oe_low_err == 0, "R4 drive outside high phase", oe_low_err, 0);
        check(stall_err == 0, "R8 request while clock high", stall_err, 0);
        mid_rst_ok = 1;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (!done || img_req || bus_oe || !cpu_rst_n || boot_mode) mid_rst_ok = 0;
        end
        check(mid_rst_ok, "R9 idle after done", mid_rst_ok, 1);
        check(fetched == NBYTES, "R9 no further byte taken", fetched, NBYTES);
    endtask

    initial begin
        void'($urandom(32'h5EED_0B07));
        run_load(1);
        run_load(2);
        rst_n = 1'b0;
        @(negedge clk);
        check(!done && boot_mode && !cpu_rst_n, "R1 re-reset clears done",
              {done, boot_mode, cpu_rst_n}, 3'b010);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule